// File: doc/BRIEF.md
# Accelerator Core Reset and Isolation Gasket Controller

This block produces the reset and the isolation enable for a hard accelerator core. The core is held in reset while any of four things is true: the external active-low reset is low, device configuration is still running, the register's run bit is 0, or the register's link bit is 0 (isolation still in place). Every reset pulse lasts at least a minimum number of cycles of the slow reference clock, even when its cause lasts for only one cycle. An access-ready flag tells software when the core's registers may be used.

Software drives the block through a three-bit gasket register with a single-cycle write strobe and read data that is always valid. For a shutdown, software first makes sure the bus is quiet, then clears the run bit, and then clears the link bit. The controller refuses writes that break this order or that clear a bit while the bus is busy, and records each refusal in a sticky error bit. Writes that leave both control bits as they are do not disturb a running core. The block has no streaming data path, so every pin is a plain level or a strobe.

Top module: `rst_gasket_ctrl`

## Requirements
- R1: core_rst is 1 whenever the synchronized ext_rst_n is 0, the synchronized cfg_busy is 1, register bit 1 (run) is 0, or register bit 0 (link) is 0. A change of the run or link bit reaches core_rst one clock after the write edge.
- R2: Each assertion of core_rst lasts at least MIN_CYC (default 2) reference-clock cycles, even when its cause is present for only one cycle.
- R3: acc_ready is 0 whenever core_rst is 1. It rises one cycle after core_rst falls.
- R4: The register layout is bit 0 = link (1 removes isolation), bit 1 = run (1 releases reset), and bit 2 = sticky error, which is cleared by writing 1 to it. reg_rdata returns {err, run, link}, and iso_en equals the inverse of the link bit.
- R5: A write that clears link while run is currently 1 is ignored as a whole, and it sets the error bit.
- R6: A write that clears run or link while bus_idle is 0 is ignored as a whole, and it sets the error bit.
- R7: A write that leaves run and link unchanged never asserts core_rst.
- R8: After sys_rst_n, the register reads 000, core_rst and iso_en are 1, and acc_ready is 0.
- R9: pwr_off_ok is 1 only when run and link are both 0 and the current reset has already lasted MIN_CYC cycles.
- R10: ext_rst_n and cfg_busy each pass through a two-flop synchronizer. A change on either pin reaches core_rst on the third rising edge after it.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Slow reference clock; all logic runs on it |
| sys_rst_n | input | 1 | Active-low reset of the controller itself |
| ext_rst_n | input | 1 | External active-low core reset request, asynchronous |
| cfg_busy | input | 1 | High while device configuration is running, asynchronous |
| bus_idle | input | 1 | High when no bus transaction to the core is pending |
| reg_wr | input | 1 | Single-cycle write strobe for the gasket register |
| reg_wdata | input | 3 | Write data {err_clear, run, link} |
| reg_rdata | output | 3 | Register contents {err, run, link} |
| core_rst | output | 1 | Active-high reset to the core |
| iso_en | output | 1 | Isolation enable, high while link is 0 |
| acc_ready | output | 1 | Core registers may be accessed |
| order_err | output | 1 | Sticky illegal-write flag |
| pwr_off_ok | output | 1 | Core supply may be removed |

## Verification
A register write is captured on the first rising edge after the strobe, so reg_rdata, iso_en and order_err are checked at the falling edge that follows it. core_rst follows one edge later and acc_ready one edge after core_rst. A change on ext_rst_n or cfg_busy takes three edges to reach core_rst, two of them spent in the synchronizer. The bench drives inputs at falling edges and counts whole clock cycles from that point. For pulse width it samples core_rst at the due edge, at the edge after it, and at the edge where release is expected.

// File: rtl/gasket_pkg.sv
package gasket_pkg;
  localparam int REG_W    = 3;
  localparam int LINK_BIT = 0;
  localparam int RUN_BIT  = 1;
  localparam int ERR_BIT  = 2;

  typedef struct packed {
    logic err;
    logic run;
    logic link;
  } gasket_reg_t;
endpackage

// File: rtl/gasket_sync.sv
module gasket_sync #(
  parameter int           W       = 2,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= st[s-1];
      end
    end
  end

  assign q_o = st[LAST];
endmodule

// File: rtl/gasket_reg.sv
module gasket_reg
  import gasket_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             bus_idle,
  output gasket_reg_t      q
);
  logic clr_run, clr_link, bad;

  always_comb begin
    clr_run  = q.run  & ~wdata[RUN_BIT];
    clr_link = q.link & ~wdata[LINK_BIT];
    // link may only drop after run is already 0, and nothing drops on a busy bus
    bad      = (clr_link & q.run) | ((clr_run | clr_link) & ~bus_idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr) begin
      if (bad) begin
        q.err <= 1'b1;
      end else begin
        q.run  <= wdata[RUN_BIT];
        q.link <= wdata[LINK_BIT];
        if (wdata[ERR_BIT]) q.err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gasket_stretch.sv
module gasket_stretch #(
  parameter int MIN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rst_o,
  output logic done_o
);
  localparam int CW = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic          rst_q;
  logic [CW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      held  <= '0;
    end else begin
      rst_q <= trig | (rst_q & (held != LAST));
      if (!rst_q)           held <= '0;
      else if (held != LAST) held <= held + 1'b1;
    end
  end

  assign rst_o  = rst_q;
  assign done_o = rst_q & (held == LAST);
endmodule

// File: rtl/rst_gasket_ctrl.sv
module rst_gasket_ctrl
  import gasket_pkg::*;
#(
  parameter int MIN_CYC = 2,
  parameter int SYNC_ST = 2
) (
  input  logic             ref_clk,
  input  logic             sys_rst_n,
  input  logic             ext_rst_n,
  input  logic             cfg_busy,
  input  logic             bus_idle,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             core_rst,
  output logic             iso_en,
  output logic             acc_ready,
  output logic             order_err,
  output logic             pwr_off_ok
);
  logic [1:0]  src_s;
  gasket_reg_t cr;
  logic        trig, rst_q, done, acc_q;

  // bit 1: external reset (reset value asserted), bit 0: config busy (reset value busy)
  gasket_sync #(.W(2), .STAGES(SYNC_ST), .RST_VAL(2'b01)) u_sync (
    .clk   (ref_clk),
    .rst_n (sys_rst_n),
    .d_i   ({ext_rst_n, cfg_busy}),
    .q_o   (src_s)
  );

  gasket_reg u_reg (
    .clk      (ref_clk),
    .rst_n    (sys_rst_n),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .bus_idle (bus_idle),
    .q        (cr)
  );

  assign trig = ~src_s[1] | src_s[0] | ~cr.run | ~cr.link;

  gasket_stretch #(.MIN_CYC(MIN_CYC)) u_stretch (
    .clk    (ref_clk),
    .rst_n  (sys_rst_n),
    .trig   (trig),
    .rst_o  (rst_q),
    .done_o (done)
  );

  always_ff @(posedge ref_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) acc_q <= 1'b0;
    else            acc_q <= ~rst_q;
  end

  assign core_rst   = rst_q;
  assign acc_ready  = acc_q & ~rst_q;
  assign iso_en     = ~cr.link;
  assign order_err  = cr.err;
  assign reg_rdata  = cr;
  assign pwr_off_ok = ~cr.run & ~cr.link & done;
endmodule

// File: rtl/gasket_ctrl_checker.sv
module gasket_ctrl_checker (
  input logic       ref_clk,
  input logic       sys_rst_n,
  input logic       bus_idle,
  input logic       reg_wr,
  input logic [2:0] reg_wdata,
  input logic [2:0] reg_rdata,
  input logic       core_rst,
  input logic       iso_en,
  input logic       acc_ready,
  input logic       order_err,
  input logic       pwr_off_ok
);
  p_cause_r1: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    (!reg_rdata[1] || !reg_rdata[0]) |=> core_rst);

  p_min_width_r2: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    $rose(core_rst) |=> core_rst);

  p_ready_low_r3: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    $fell(core_rst) |-> !acc_ready);

  p_order_r5: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    (reg_wr && reg_rdata[1] && reg_rdata[0] && !reg_wdata[0])
      |=> (order_err && $stable(reg_rdata[1:0])));

  p_busy_r6: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    (reg_wr && !bus_idle &&
     ((reg_rdata[1] && !reg_wdata[1]) || (reg_rdata[0] && !reg_wdata[0])))
      |=> (order_err && $stable(reg_rdata[1:0])));

  p_pwr_ok_r9: assert property (@(posedge ref_clk) disable iff (!sys_rst_n)
    pwr_off_ok |-> (core_rst && iso_en && !reg_rdata[1]));
endmodule

bind rst_gasket_ctrl gasket_ctrl_checker u_chk (
  .ref_clk    (ref_clk),
  .sys_rst_n  (sys_rst_n),
  .bus_idle   (bus_idle),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .core_rst   (core_rst),
  .iso_en     (iso_en),
  .acc_ready  (acc_ready),
  .order_err  (order_err),
  .pwr_off_ok (pwr_off_ok)
);

// File: tb/rst_gasket_ctrl_test.sv
module rst_gasket_ctrl_test;
  localparam time CLK_PER = 20ns;

  logic       ref_clk = 1'b0;
  logic       sys_rst_n, ext_rst_n, cfg_busy, bus_idle, reg_wr;
  logic [2:0] reg_wdata, reg_rdata;
  logic       core_rst, iso_en, acc_ready, order_err, pwr_off_ok;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done_flag = 1'b0;

  always #(CLK_PER/2) ref_clk = ~ref_clk;

  rst_gasket_ctrl uut (
    .ref_clk(ref_clk), .sys_rst_n(sys_rst_n), .ext_rst_n(ext_rst_n),
    .cfg_busy(cfg_busy), .bus_idle(bus_idle), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rst(core_rst),
    .iso_en(iso_en), .acc_ready(acc_ready), .order_err(order_err),
    .pwr_off_ok(pwr_off_ok)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge ref_clk);
      @(negedge ref_clk);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset;  // R8
    chk("R8 rdata", {1'b0, reg_rdata}, 4'h0);
    chk("R8 core_rst/iso/acc", {1'b0, core_rst, iso_en, acc_ready}, 4'b0110);
    chk("R9 pwr_ok after reset", {3'b0, pwr_off_ok}, 4'h1);
  endtask

  task automatic t_release;  // R4 R1 R3
    wr(3'b011);
    chk("R4 rdata after release", {1'b0, reg_rdata}, 4'h3);
    chk("R4 iso_en follows link", {3'b0, iso_en}, 4'h0);
    chk("R9 pwr_ok drops", {3'b0, pwr_off_ok}, 4'h0);
    chk("R1 reset one edge later", {3'b0, core_rst}, 4'h1);
    step();
    chk("R1 reset released", {3'b0, core_rst}, 4'h0);
    chk("R3 ready still low", {3'b0, acc_ready}, 4'h0);
    step();
    chk("R3 ready rises", {3'b0, acc_ready}, 4'h1);
  endtask

  task automatic t_noop;  // R7
    logic seen = 1'b0;
    wr(3'b011);
    for (int i = 0; i < 4; i++) begin
      seen |= core_rst;
      step();
    end
    chk("R7 unchanged write keeps core running", {3'b0, seen}, 4'h0);
  endtask

  task automatic t_ext_pulse;  // R10 R2 R3 R1
    ext_rst_n = 1'b0;
    step();
    ext_rst_n = 1'b1;
    step();
    chk("R10 no reset after two edges", {3'b0, core_rst}, 4'h0);
    step();
    chk("R1 ext reset reaches core", {3'b0, core_rst}, 4'h1);
    chk("R3 ready low in reset", {3'b0, acc_ready}, 4'h0);
    step();
    chk("R2 stretched second cycle", {3'b0, core_rst}, 4'h1);
    step();
    chk("R2 release after min width", {3'b0, core_rst}, 4'h0);
    chk("R3 ready waits one cycle", {3'b0, acc_ready}, 4'h0);
    step();
    chk("R3 ready back", {3'b0, acc_ready}, 4'h1);
  endtask

  task automatic t_cfg;  // R1 R10
    cfg_busy = 1'b1;
    step(3);
    chk("R1 cfg busy holds reset", {3'b0, core_rst}, 4'h1);
    step(2);
    cfg_busy = 1'b0;
    step(2);
    chk("R10 cfg release still synchronizing", {3'b0, core_rst}, 4'h1);
    step();
    chk("R1 cfg done releases", {3'b0, core_rst}, 4'h0);
    step();
  endtask

  task automatic t_order;  // R5 R4
    wr(3'b010);
    chk("R5 link clear while run refused", {1'b0, reg_rdata}, 4'h7);
    step();
    chk("R5 core untouched", {2'b0, core_rst, iso_en}, 4'h0);
    wr(3'b111);
    chk("R4 err cleared by writing 1", {1'b0, reg_rdata}, 4'h3);
  endtask

  task automatic t_busy;  // R6
    bus_idle = 1'b0;
    wr(3'b001);
    chk("R6 clear on busy bus refused", {1'b0, reg_rdata}, 4'h7);
    step();
    chk("R6 core keeps running", {3'b0, core_rst}, 4'h0);
    bus_idle = 1'b1;
    wr(3'b111);
    chk("R4 err clear again", {2'b0, order_err, core_rst}, 4'h0);
  endtask

  task automatic t_reg_pulse;  // R2 R1
    wr(3'b001);
    wr(3'b011);
    chk("R1 run cleared asserts reset", {3'b0, core_rst}, 4'h1);
    step();
    chk("R2 register pulse stretched", {3'b0, core_rst}, 4'h1);
    step();
    chk("R2 register pulse ends", {3'b0, core_rst}, 4'h0);
    step(2);
  endtask

  task automatic t_shutdown;  // R9 R4
    wr(3'b001);
    chk("R4 run cleared, isolation still off", {2'b0, reg_rdata[1], iso_en}, 4'h0);
    wr(3'b000);
    chk("R4 link cleared", {1'b0, reg_rdata}, 4'h0);
    chk("R4 isolation on", {3'b0, iso_en}, 4'h1);
    chk("R9 pwr_ok waits for stretch", {3'b0, pwr_off_ok}, 4'h0);
    step();
    chk("R9 pwr_ok granted", {3'b0, pwr_off_ok}, 4'h1);
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    sys_rst_n = 1'b0; ext_rst_n = 1'b1; cfg_busy = 1'b0; bus_idle = 1'b1;
    reg_wr = 1'b0; reg_wdata = '0;
    step(3);
    sys_rst_n = 1'b1;
    step(4);
    t_reset();
    t_release();
    t_noop();
    t_ext_pulse();
    t_cfg();
    t_order();
    t_busy();
    t_reg_pulse();
    t_shutdown();
    done_flag = 1'b1;
    finish_up();
  end
endmodule